// File: doc/BRIEF.md
# Locked Split Result Register

This block keeps the latest 10-bit conversion result and lets a byte-wide bus fetch it as two bytes. The low byte carries result bits 7:0. The high byte carries bits 9:8 in its two lowest positions. Software fetches the low byte first and the high byte second. A read lock makes sure the two bytes it collects always belong to the same conversion.

A read of the low byte freezes the stored value. Any conversion that finishes while the value is frozen is thrown away. A read of the high byte releases the freeze. Every finished conversion raises an interrupt flag, and this includes the ones that were thrown away. The flag stays set until an acknowledge pulse clears it. The read data outputs show the stored value directly, so a read strobe sees what was stored before the current clock edge.

Top module: `split_res_reg`

## Requirements
- R1: After reset the register is unlocked, both read bytes are 0x00 and the interrupt flag is 0.
- R2: The low read byte equals stored bits 7:0. The high read byte has stored bits 9:8 at its positions 1:0 and zero at positions 7:2.
- R3: A completion strobe while the register is unlocked, with no low read in that cycle, stores the new value. Both read bytes show it from the next cycle on.
- R4: A low read locks the register from the next cycle. While locked, completions leave both read bytes unchanged.
- R5: A high read that comes after a low read unlocks the register, and the next completion updates both bytes.
- R6: A high read without a prior low read changes nothing, and the register stays unlocked.
- R7: If a completion and a high read of a locked register fall in the same cycle, the read returns the old bytes and the new value is discarded.
- R8: If a completion and a low read fall in the same cycle, the new value is discarded, so the pair read stays consistent.
- R9: The interrupt flag is 1 from the cycle after every completion strobe, whether the result was stored or discarded.
- R10: An acknowledge clears the flag on the next cycle. If a completion arrives in the same cycle as an acknowledge, the flag stays set.
- R11: If low and high reads arrive in the same cycle, the low read wins and the register ends up locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| done_i | input | 1 | Conversion completion strobe |
| done_value_i | input | 10 | Result that comes with the completion strobe |
| rd_lo_i | input | 1 | Low byte read strobe |
| rd_hi_i | input | 1 | High byte read strobe |
| irq_ack_i | input | 1 | Interrupt acknowledge |
| lo_data_o | output | 8 | Low read byte |
| hi_data_o | output | 8 | High read byte |
| irq_o | output | 1 | Completion interrupt flag |

## Verification
A completion can land in the same cycle as either read strobe, and it can also land in the same cycle as an acknowledge. The bench drives each of these pairs on purpose.

- **Completion with a high read:** the returned bytes must be the old ones, and the following cycles must still show them.
- **Completion with a low read:** the new value must never appear.
- **Completion with an acknowledge:** the flag must stay set.

A behavioural model in the bench tracks the value, the lock and the flag. Its state is compared with the outputs on every clock.

// File: rtl/split_res_pkg.sv
package split_res_pkg;

    localparam int RES_W  = 10;
    localparam int BYTE_W = 8;

    typedef enum logic {
        LK_OPEN = 1'b0,
        LK_HELD = 1'b1
    } lock_e;

    typedef struct packed {
        logic done;
        logic rd_lo;
        logic rd_hi;
        logic ack;
    } evt_t;

    function automatic lock_e lock_next(lock_e cur, logic rd_lo, logic rd_hi);
        if (rd_lo)
            return LK_HELD;
        else if (rd_hi)
            return LK_OPEN;
        else
            return cur;
    endfunction

endpackage

// File: rtl/split_res_lock.sv
module split_res_lock
    import split_res_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  evt_t evt,
    output logic locked_o,
    output logic upd_en_o
);

    lock_e state_q;

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= LK_OPEN;
        else
            state_q <= lock_next(state_q, evt.rd_lo, evt.rd_hi);
    end

    assign locked_o = (state_q == LK_HELD);
    assign upd_en_o = evt.done && (state_q == LK_OPEN) && !evt.rd_lo;

    AST_RDLO_LOCKS: assert property (@(posedge clk) disable iff (rst)
        evt.rd_lo |=> locked_o); // R4
    AST_BOTH_LOCKS: assert property (@(posedge clk) disable iff (rst)
        (evt.rd_lo && evt.rd_hi) |=> locked_o); // R11
    AST_HI_UNLOCKS: assert property (@(posedge clk) disable iff (rst)
        (evt.rd_hi && !evt.rd_lo) |=> !locked_o); // R5

endmodule

// File: rtl/split_res_store.sv
module split_res_store #(
    parameter int RES_W  = split_res_pkg::RES_W,
    parameter int BYTE_W = split_res_pkg::BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_en,
    input  logic [RES_W-1:0]  value_i,
    output logic [BYTE_W-1:0] lo_o,
    output logic [BYTE_W-1:0] hi_o
);

    localparam int HI_W  = RES_W - BYTE_W;
    localparam int PAD_W = BYTE_W - HI_W;

    logic [RES_W-1:0] res_q;

    always_ff @(posedge clk) begin
        if (rst)
            res_q <= '0;
        else if (upd_en)
            res_q <= value_i;
    end

    assign lo_o = res_q[BYTE_W-1:0];

    generate
        if (PAD_W > 0) begin : g_pad
            assign hi_o = {{PAD_W{1'b0}}, res_q[RES_W-1:BYTE_W]};
        end else begin : g_full
            assign hi_o = res_q[RES_W-1:BYTE_W];
        end
    endgenerate

endmodule

// File: rtl/split_res_irq.sv
module split_res_irq (
    input  logic clk,
    input  logic rst,
    input  logic done,
    input  logic ack,
    output logic irq_o
);

    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst)
            flag_q <= 1'b0;
        else if (done)
            flag_q <= 1'b1;
        else if (ack)
            flag_q <= 1'b0;
    end

    assign irq_o = flag_q;

    AST_IRQ_ON_DONE: assert property (@(posedge clk) disable iff (rst)
        done |=> irq_o); // R9
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (ack && !done) |=> !irq_o); // R10

endmodule

// File: rtl/split_res_reg.sv
module split_res_reg
    import split_res_pkg::*;
#(
    parameter int RES_W  = split_res_pkg::RES_W,
    parameter int BYTE_W = split_res_pkg::BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              done_i,
    input  logic [RES_W-1:0]  done_value_i,
    input  logic              rd_lo_i,
    input  logic              rd_hi_i,
    input  logic              irq_ack_i,
    output logic [BYTE_W-1:0] lo_data_o,
    output logic [BYTE_W-1:0] hi_data_o,
    output logic              irq_o
);

    evt_t evt;
    logic locked;
    logic upd_en;

    assign evt = '{done: done_i, rd_lo: rd_lo_i, rd_hi: rd_hi_i, ack: irq_ack_i};

    split_res_lock u_lock (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .locked_o (locked),
        .upd_en_o (upd_en)
    );

    split_res_store #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .upd_en  (upd_en),
        .value_i (done_value_i),
        .lo_o    (lo_data_o),
        .hi_o    (hi_data_o)
    );

    split_res_irq u_irq (
        .clk   (clk),
        .rst   (rst),
        .done  (done_i),
        .ack   (irq_ack_i),
        .irq_o (irq_o)
    );

    AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (rst)
        locked |=> ($stable(lo_data_o) && $stable(hi_data_o))); // R4
    AST_RDLO_DROPS: assert property (@(posedge clk) disable iff (rst)
        rd_lo_i |=> ($stable(lo_data_o) && $stable(hi_data_o))); // R8
    AST_UPDATE: assert property (@(posedge clk) disable iff (rst)
        (done_i && !locked && !rd_lo_i) |=> (lo_data_o == $past(done_value_i[BYTE_W-1:0]))); // R3
    AST_HI_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        hi_data_o[BYTE_W-1:RES_W-BYTE_W] == '0); // R2

endmodule

// File: tb/split_res_reg_bench.sv
module split_res_reg_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       done_i = 1'b0;
    logic [9:0] done_value_i = '0;
    logic       rd_lo_i = 1'b0;
    logic       rd_hi_i = 1'b0;
    logic       irq_ack_i = 1'b0;
    logic [7:0] lo_data_o;
    logic [7:0] hi_data_o;
    logic       irq_o;

    int total = 0;
    int bad   = 0;

    // behavioural reference state
    int mdl_val  = 0;
    bit mdl_lock = 0;
    bit mdl_irq  = 0;

    always #10 clk = ~clk;

    split_res_reg u_split_res_reg (
        .clk          (clk),
        .rst          (rst),
        .done_i       (done_i),
        .done_value_i (done_value_i),
        .rd_lo_i      (rd_lo_i),
        .rd_hi_i      (rd_hi_i),
        .irq_ack_i    (irq_ack_i),
        .lo_data_o    (lo_data_o),
        .hi_data_o    (hi_data_o),
        .irq_o        (irq_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // one clock: drive at negedge, compare with model mid-cycle, update model at edge
    task automatic step(input bit d, input int v, input bit lo, input bit hi, input bit ack);
        @(negedge clk);
        done_i = d; done_value_i = v[9:0]; rd_lo_i = lo; rd_hi_i = hi; irq_ack_i = ack;
        #5;
        chk("R2 low byte vs model", int'(lo_data_o), mdl_val & 8'hFF);
        chk("R2 high byte vs model", int'(hi_data_o), (mdl_val >> 8) & 3);
        chk("R9 flag vs model", int'(irq_o), int'(mdl_irq));
        @(posedge clk);
        if (d && !mdl_lock && !lo) mdl_val = v & 10'h3FF;
        if (lo) mdl_lock = 1;
        else if (hi) mdl_lock = 0;
        if (d) mdl_irq = 1;
        else if (ack) mdl_irq = 0;
        #2;
        done_i = 0; rd_lo_i = 0; rd_hi_i = 0; irq_ack_i = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=hung expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        // R1 reset state
        chk("R1 low byte", int'(lo_data_o), 0);
        chk("R1 high byte", int'(hi_data_o), 0);
        chk("R1 flag", int'(irq_o), 0);

        // R3 / R2 unlocked update
        step(1, 'h2A5, 0, 0, 0);
        chk("R3 low byte", int'(lo_data_o), 'hA5);
        chk("R2 high byte", int'(hi_data_o), 'h02);
        chk("R9 flag set", int'(irq_o), 1);
        step(0, 0, 0, 0, 1);
        chk("R10 ack clears", int'(irq_o), 0);

        // R4 lock, then dropped completion still flags
        step(0, 0, 1, 0, 0);
        step(1, 'h15A, 0, 0, 0);
        chk("R4 low frozen", int'(lo_data_o), 'hA5);
        chk("R4 high frozen", int'(hi_data_o), 'h02);
        chk("R9 flag on dropped", int'(irq_o), 1);

        // R7 completion with high read
        @(negedge clk); #5;
        chk("R7 read returns old low", int'(lo_data_o), 'hA5);
        step(1, 'h3FF, 0, 1, 1);
        chk("R7 new value discarded", int'(lo_data_o), 'hA5);
        chk("R10 set wins over ack", int'(irq_o), 1);

        // R5 unlocked again
        step(1, 'h3C3, 0, 0, 0);
        chk("R5 low after unlock", int'(lo_data_o), 'hC3);
        chk("R5 high after unlock", int'(hi_data_o), 'h03);

        // R6 lone high read
        step(0, 0, 0, 1, 0);
        chk("R6 no change", int'(lo_data_o), 'hC3);
        step(1, 'h111, 0, 0, 0);
        chk("R6 still unlocked", int'(lo_data_o), 'h11);
        chk("R6 high", int'(hi_data_o), 'h01);

        // R8 completion with low read
        step(1, 'h0F0, 1, 0, 0);
        chk("R8 discarded", int'(lo_data_o), 'h11);
        step(0, 0, 0, 1, 0);
        step(1, 'h0F0, 0, 0, 0);
        chk("R8 later update", int'(lo_data_o), 'hF0);

        // R11 both reads together
        step(0, 0, 1, 1, 0);
        step(1, 'h222, 0, 0, 0);
        chk("R11 low wins, locked", int'(lo_data_o), 'hF0);
        step(0, 0, 0, 1, 1);
        chk("R10 ack alone clears", int'(irq_o), 0);
        step(1, 'h222, 0, 0, 0);
        chk("R11 unlocked after high", int'(lo_data_o), 'h22);
        chk("R2 high bits", int'(hi_data_o), 'h02);

        // R1 reset mid-run
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #2 rst = 1'b0;
        mdl_val = 0; mdl_lock = 0; mdl_irq = 0;
        chk("R1 reset clears low", int'(lo_data_o), 0);
        chk("R1 reset clears flag", int'(irq_o), 0);
        step(0, 0, 0, 0, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule